// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the architectural side of exception entry for a 32-bit core whose registers use big-endian bit numbering (bit 0 is the most significant bit). It recognises two exception classes. The system reset class comes from the external interrupt-request line, a soft reset pulse or a hard reset pulse. The machine check class comes from a bus error seen on an address or data tenure. For each exception it saves the interrupted state into the two save/restore registers, builds the new machine state and redirects instruction fetch to the exception vector.

A machine check taken while machine checks are disabled does not vector. With the debug strap set, it raises a one-cycle debug-entry flag. Without the strap, it enters a sticky checkstop state and sends a one-cycle reset request to the system interface. In checkstop only a hard reset is acted on. The block also serves return-from-interrupt: it restores the machine state from the saved copy and redirects fetch to the saved address. A separate load strobe lets the pipeline write the machine state directly.

All outputs are registered. A redirect shows up as `fetch_vld_o` high for one cycle together with `fetch_addr_o`, on the clock edge after the request.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A hard reset, a soft reset or `irq_i` makes the next cycle show `fetch_vld_o`=1 and `fetch_addr_o` = base + 0x00100.
- R2: A bus error while MSR bit 19 (machine-check enable, mask 0x0000_1000) is 1 makes the next cycle show `fetch_vld_o`=1 and `fetch_addr_o` = base + 0x00200.
- R3: On any exception entry, `srr0_o` is loaded with `next_ea_i`.
- R4: On entry, `srr1_o` gets the old MSR with bits 1–4 and 10–15 cleared and all other bits copied, i.e. MSR & 0x87C0_FFFF. This copies the recoverable bit 30 (mask 0x0000_0002).
- R5: On entry, the new MSR keeps bit 25 (vector-high, mask 0x40) and bit 19 (mask 0x1000). Bit 31 (little-endian mode, mask 0x1) takes the old bit 15 (mask 0x0001_0000). Every other bit is 0.
- R6: The vector base is 0x0000_0000 when the MSR vector-high bit is 0 and 0xFFF0_0000 when it is 1.
- R7: A bus error while machine checks are disabled and `dbg_en_i`=1 pulses `debug_entry_o` for one cycle. It causes no redirect and leaves the MSR, SRR0 and SRR1 unchanged.
- R8: A bus error while machine checks are disabled and `dbg_en_i`=0 sets `checkstop_o` and pulses `sys_rst_req_o` for exactly one cycle, with no redirect.
- R9: While `checkstop_o`=1, `irq_i`, `soft_rst_i`, `bus_err_i`, `rfi_i` and `msr_ld_i` are ignored. A hard reset clears checkstop and takes the reset vector.
- R10: When more than one request is present in a cycle, the system reset class wins over machine check, and machine check wins over return-from-interrupt.
- R11: A return-from-interrupt pulse loads the MSR from SRR1 and redirects fetch to SRR0 on the next cycle.
- R12: After `rst_ni`, the MSR is 0x0000_0040, SRR0 and SRR1 are 0, and `checkstop_o`, `fetch_vld_o`, `debug_entry_o` and `sys_rst_req_o` are 0.
- R13: `msr_ld_i` with no other request loads `msr_wd_i` into the MSR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | 1 | External request for a system reset exception |
| soft_rst_i | input | 1 | Soft reset pulse |
| hard_rst_i | input | 1 | Hard reset pulse; also clears checkstop |
| bus_err_i | input | 1 | Bus error on an address or data tenure |
| rfi_i | input | 1 | Return-from-interrupt pulse |
| msr_ld_i | input | 1 | Direct MSR load strobe |
| msr_wd_i | input | 32 | Value for a direct MSR load |
| next_ea_i | input | 32 | Effective address of the next instruction of the running flow |
| dbg_en_i | input | 1 | Debug-enable strap |
| fetch_addr_o | output | 32 | Redirect fetch address |
| fetch_vld_o | output | 1 | One-cycle redirect strobe |
| srr0_o | output | 32 | Saved return address |
| srr1_o | output | 32 | Saved machine state |
| msr_o | output | 32 | Current machine state |
| checkstop_o | output | 1 | Sticky checkstop state |
| debug_entry_o | output | 1 | One-cycle request to enter debug mode |
| sys_rst_req_o | output | 1 | One-cycle automatic-reset request on checkstop entry |

## Verification
The assertions check, on every cycle, the relation between each entry and its result: the vector address for the old vector-high bit, the SRR0 and SRR1 capture and the rebuilt MSR. They also check that checkstop holds until a hard reset with no redirect, that the reset request is a single pulse inside checkstop, and that debug entry never redirects. What only the bench scenarios can show are the choices among requests in the same cycle, the round trip through return-from-interrupt, and the fact that a masked MSR load and masked interrupts in checkstop leave state untouched. They also show the reset values and the exact masks for chosen MSR patterns.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN = 32;
  // big-endian bit k sits at little-endian index XLEN-1-k
  localparam int MSR_ILE = XLEN - 1 - 15;
  localparam int MSR_ME  = XLEN - 1 - 19;
  localparam int MSR_IP  = XLEN - 1 - 25;
  localparam int MSR_RI  = XLEN - 1 - 30;
  localparam int MSR_LE  = XLEN - 1 - 31;
  // SRR1 keeps bit 0, bits 5..9 and 16..31 (big-endian)
  localparam logic [XLEN-1:0] SRR1_KEEP = 32'h87C0_FFFF;

  typedef enum logic [2:0] {
    EV_NONE, EV_SYSRST, EV_MCE, EV_DBG, EV_CHKSTOP, EV_RFI, EV_MSRLD
  } exc_ev_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic    hard_rst_i,
  input  logic    soft_rst_i,
  input  logic    irq_i,
  input  logic    bus_err_i,
  input  logic    rfi_i,
  input  logic    msr_ld_i,
  input  logic    me_i,
  input  logic    dbg_en_i,
  input  logic    cs_i,
  output exc_ev_e ev_o
);
  always_comb begin
    ev_o = EV_NONE;
    if (hard_rst_i)                ev_o = EV_SYSRST;
    else if (cs_i)                 ev_o = EV_NONE;
    else if (soft_rst_i || irq_i)  ev_o = EV_SYSRST;
    else if (bus_err_i) begin
      if (me_i)                    ev_o = EV_MCE;
      else if (dbg_en_i)           ev_o = EV_DBG;
      else                         ev_o = EV_CHKSTOP;
    end
    else if (rfi_i)                ev_o = EV_RFI;
    else if (msr_ld_i)             ev_o = EV_MSRLD;
  end
endmodule

// File: rtl/exc_save_xform.sv
module exc_save_xform
  import exc_pkg::*;
(
  input  logic [XLEN-1:0] msr_i,
  output logic [XLEN-1:0] srr1_o,
  output logic [XLEN-1:0] msr_ent_o
);
  assign srr1_o = msr_i & SRR1_KEEP;

  always_comb begin
    msr_ent_o         = '0;
    msr_ent_o[MSR_IP] = msr_i[MSR_IP];
    msr_ent_o[MSR_ME] = msr_i[MSR_ME];
    msr_ent_o[MSR_LE] = msr_i[MSR_ILE];
  end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen #(
  parameter int          AW          = 32,
  parameter logic [31:0] VEC_HI_BASE = 32'hFFF0_0000,
  parameter logic [31:0] VEC_RST_OFF = 32'h0000_0100,
  parameter logic [31:0] VEC_MCE_OFF = 32'h0000_0200
) (
  input  logic          hi_i,
  input  logic          mce_i,
  output logic [AW-1:0] vec_o
);
  logic [AW-1:0] base, off;
  assign base  = hi_i  ? VEC_HI_BASE[AW-1:0] : '0;
  assign off   = mce_i ? VEC_MCE_OFF[AW-1:0] : VEC_RST_OFF[AW-1:0];
  assign vec_o = base + off;
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter logic [31:0] VEC_HI_BASE = 32'hFFF0_0000,
  parameter logic [31:0] VEC_RST_OFF = 32'h0000_0100,
  parameter logic [31:0] VEC_MCE_OFF = 32'h0000_0200,
  parameter logic [31:0] MSR_RST_VAL = 32'h0000_0040
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        irq_i,
  input  logic        soft_rst_i,
  input  logic        hard_rst_i,
  input  logic        bus_err_i,
  input  logic        rfi_i,
  input  logic        msr_ld_i,
  input  logic [31:0] msr_wd_i,
  input  logic [31:0] next_ea_i,
  input  logic        dbg_en_i,
  output logic [31:0] fetch_addr_o,
  output logic        fetch_vld_o,
  output logic [31:0] srr0_o,
  output logic [31:0] srr1_o,
  output logic [31:0] msr_o,
  output logic        checkstop_o,
  output logic        debug_entry_o,
  output logic        sys_rst_req_o
);
  exc_ev_e         ev;
  logic [XLEN-1:0] srr1_nx, msr_ent, vec;
  logic [XLEN-1:0] msr_q, srr0_q, srr1_q, fetch_q;
  logic            vld_q, cs_q, dbg_q, req_q;

  exc_arbiter u_arb (
    .hard_rst_i (hard_rst_i),
    .soft_rst_i (soft_rst_i),
    .irq_i      (irq_i),
    .bus_err_i  (bus_err_i),
    .rfi_i      (rfi_i),
    .msr_ld_i   (msr_ld_i),
    .me_i       (msr_q[MSR_ME]),
    .dbg_en_i   (dbg_en_i),
    .cs_i       (cs_q),
    .ev_o       (ev)
  );

  exc_save_xform u_xf (
    .msr_i     (msr_q),
    .srr1_o    (srr1_nx),
    .msr_ent_o (msr_ent)
  );

  exc_vector_gen #(
    .AW          (XLEN),
    .VEC_HI_BASE (VEC_HI_BASE),
    .VEC_RST_OFF (VEC_RST_OFF),
    .VEC_MCE_OFF (VEC_MCE_OFF)
  ) u_vec (
    .hi_i  (msr_q[MSR_IP]),
    .mce_i (ev == EV_MCE),
    .vec_o (vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msr_q   <= MSR_RST_VAL;
      srr0_q  <= '0;
      srr1_q  <= '0;
      fetch_q <= '0;
      vld_q   <= 1'b0;
      cs_q    <= 1'b0;
      dbg_q   <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      dbg_q <= 1'b0;
      req_q <= 1'b0;
      unique case (ev)
        EV_SYSRST, EV_MCE: begin
          srr0_q  <= next_ea_i;
          srr1_q  <= srr1_nx;
          msr_q   <= msr_ent;
          fetch_q <= vec;
          vld_q   <= 1'b1;
          cs_q    <= 1'b0;  // only a hard reset reaches here in checkstop
        end
        EV_CHKSTOP: begin
          cs_q  <= 1'b1;
          req_q <= 1'b1;
        end
        EV_DBG: dbg_q <= 1'b1;
        EV_RFI: begin
          msr_q   <= srr1_q;
          fetch_q <= srr0_q;
          vld_q   <= 1'b1;
        end
        EV_MSRLD: msr_q <= msr_wd_i;
        default: ;
      endcase
    end
  end

  assign fetch_addr_o  = fetch_q;
  assign fetch_vld_o   = vld_q;
  assign srr0_o        = srr0_q;
  assign srr1_o        = srr1_q;
  assign msr_o         = msr_q;
  assign checkstop_o   = cs_q;
  assign debug_entry_o = dbg_q;
  assign sys_rst_req_o = req_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_pkg::*;
#(
  parameter logic [31:0] VEC_HI_BASE = 32'hFFF0_0000,
  parameter logic [31:0] VEC_RST_OFF = 32'h0000_0100,
  parameter logic [31:0] VEC_MCE_OFF = 32'h0000_0200
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        irq_i,
  input logic        soft_rst_i,
  input logic        hard_rst_i,
  input logic        bus_err_i,
  input logic [31:0] next_ea_i,
  input logic        dbg_en_i,
  input logic [31:0] fetch_addr_o,
  input logic        fetch_vld_o,
  input logic [31:0] srr0_o,
  input logic [31:0] srr1_o,
  input logic [31:0] msr_o,
  input logic        checkstop_o,
  input logic        debug_entry_o,
  input logic        sys_rst_req_o
);
  logic sysrst, mce, ent;
  assign sysrst = hard_rst_i || (!checkstop_o && (irq_i || soft_rst_i));
  assign mce    = !sysrst && !checkstop_o && bus_err_i && msr_o[MSR_ME];
  assign ent    = sysrst || mce;

  assert_rst_vec_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sysrst |=> fetch_vld_o &&
      fetch_addr_o == (($past(msr_o[MSR_IP]) ? VEC_HI_BASE : 32'h0) + VEC_RST_OFF));

  assert_mce_vec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mce |=> fetch_vld_o &&
      fetch_addr_o == (($past(msr_o[MSR_IP]) ? VEC_HI_BASE : 32'h0) + VEC_MCE_OFF));

  assert_srr0_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent |=> srr0_o == $past(next_ea_i));

  assert_srr1_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent |=> srr1_o == ($past(msr_o) & SRR1_KEEP));

  assert_msr_ent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent |=> (msr_o & ~32'h0000_1041) == 32'h0 &&
            msr_o[MSR_IP] == $past(msr_o[MSR_IP]) &&
            msr_o[MSR_ME] == $past(msr_o[MSR_ME]) &&
            msr_o[MSR_LE] == $past(msr_o[MSR_ILE]));

  assert_dbg_entry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sysrst && !checkstop_o && bus_err_i && !msr_o[MSR_ME] && dbg_en_i)
      |=> debug_entry_o && !fetch_vld_o && $stable(msr_o));

  assert_req_in_cs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |-> checkstop_o);

  assert_req_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_req_o |=> !sys_rst_req_o);

  assert_cs_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (checkstop_o && !hard_rst_i) |=> checkstop_o && !fetch_vld_o && $stable(msr_o));
endmodule

bind exc_entry_ctrl exc_entry_chk #(
  .VEC_HI_BASE (VEC_HI_BASE),
  .VEC_RST_OFF (VEC_RST_OFF),
  .VEC_MCE_OFF (VEC_MCE_OFF)
) u_chk (.*);

// File: tb/tb_exc_entry_ctrl.sv
`timescale 1ns/1ps
module tb_exc_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        irq_i = 0, soft_rst_i = 0, hard_rst_i = 0, bus_err_i = 0;
  logic        rfi_i = 0, msr_ld_i = 0, dbg_en_i = 0;
  logic [31:0] msr_wd_i = '0, next_ea_i = '0;
  logic [31:0] fetch_addr_o, srr0_o, srr1_o, msr_o;
  logic        fetch_vld_o, checkstop_o, debug_entry_o, sys_rst_req_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  exc_entry_ctrl dut (.*, .clk_i(clk));

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic clr();
    irq_i = 0; soft_rst_i = 0; hard_rst_i = 0; bus_err_i = 0;
    rfi_i = 0; msr_ld_i = 0;
  endtask

  task automatic load_msr(logic [31:0] v);
    msr_ld_i = 1; msr_wd_i = v; tick(); clr();
  endtask

  function automatic logic [31:0] ref_srr1(logic [31:0] m);
    return m & 32'h87C0_FFFF;
  endfunction
  function automatic logic [31:0] ref_msr(logic [31:0] m);
    return (m & 32'h0000_1040) | {31'b0, m[16]};
  endfunction

  // {event(0 irq,1 soft,2 hard,3 bus error), msr, next_ea, expected fetch}
  localparam logic [97:0] VEC [6] = '{
    {2'd0, 32'h0000_0000, 32'h1000_0004, 32'h0000_0100},
    {2'd1, 32'hFFFF_FFFF, 32'h2000_0008, 32'hFFF0_0100},
    {2'd3, 32'h0001_1003, 32'h0000_0003, 32'h0000_0200},
    {2'd2, 32'h0001_0040, 32'h4444_0010, 32'hFFF0_0100},
    {2'd3, 32'h7800_1042, 32'h5555_0020, 32'hFFF0_0200},
    {2'd0, 32'hA5A5_5A5A, 32'h6666_0030, 32'hFFF0_0100}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R12 reset state
    chk("R12 msr", msr_o, 32'h0000_0040);
    chk("R12 srr0", srr0_o, 0);
    chk("R12 srr1", srr1_o, 0);
    chk("R12 flags", {28'b0, checkstop_o, fetch_vld_o, debug_entry_o, sys_rst_req_o}, 0);
    rst_ni = 1;
    tick();

    // table: R1 R2 R3 R4 R5 R6
    for (int i = 0; i < 6; i++) begin
      logic [97:0] v;
      v = VEC[i];
      load_msr(v[95:64]);
      chk("R13 msr load", msr_o, v[95:64]);
      next_ea_i = v[63:32];
      case (v[97:96])
        2'd0: irq_i = 1;
        2'd1: soft_rst_i = 1;
        2'd2: hard_rst_i = 1;
        default: bus_err_i = 1;
      endcase
      tick(); clr();
      chk("R1 R2 R6 fetch vld", {31'b0, fetch_vld_o}, 1);
      chk("R1 R2 R6 fetch addr", fetch_addr_o, v[31:0]);
      chk("R3 srr0", srr0_o, v[63:32]);
      chk("R4 srr1", srr1_o, ref_srr1(v[95:64]));
      chk("R5 msr", msr_o, ref_msr(v[95:64]));
      tick();
      chk("R1 vld pulse", {31'b0, fetch_vld_o}, 0);
    end

    // R11 return from last entry
    rfi_i = 1; tick(); clr();
    chk("R11 rfi msr", msr_o, ref_srr1(32'hA5A5_5A5A));
    chk("R11 rfi fetch", fetch_addr_o, 32'h6666_0030);
    chk("R11 rfi vld", {31'b0, fetch_vld_o}, 1);

    // R10 reset class over machine check
    load_msr(32'h0000_1000);
    next_ea_i = 32'h0000_7000;
    irq_i = 1; bus_err_i = 1; tick(); clr();
    chk("R10 irq over mce", fetch_addr_o, 32'h0000_0100);
    // R10 machine check over rfi
    next_ea_i = 32'h0000_8000;
    rfi_i = 1; bus_err_i = 1; tick(); clr();
    chk("R10 mce over rfi", fetch_addr_o, 32'h0000_0200);
    chk("R10 mce srr0", srr0_o, 32'h0000_8000);

    // R7 debug entry
    load_msr(32'h0000_0040);
    dbg_en_i = 1; next_ea_i = 32'h0000_9000;
    bus_err_i = 1; tick(); clr();
    chk("R7 dbg flag", {31'b0, debug_entry_o}, 1);
    chk("R7 no redirect", {31'b0, fetch_vld_o}, 0);
    chk("R7 msr kept", msr_o, 32'h0000_0040);
    chk("R7 srr0 kept", srr0_o, 32'h0000_8000);
    chk("R7 no checkstop", {31'b0, checkstop_o}, 0);
    tick();
    chk("R7 dbg pulse", {31'b0, debug_entry_o}, 0);

    // R8 checkstop
    dbg_en_i = 0;
    load_msr(32'h0000_0000);
    bus_err_i = 1; tick(); clr();
    chk("R8 checkstop", {31'b0, checkstop_o}, 1);
    chk("R8 req", {31'b0, sys_rst_req_o}, 1);
    chk("R8 no redirect", {31'b0, fetch_vld_o}, 0);
    tick();
    chk("R8 req pulse", {31'b0, sys_rst_req_o}, 0);

    // R9 masked requests in checkstop
    irq_i = 1; tick(); clr();
    chk("R9 irq ignored", {30'b0, checkstop_o, fetch_vld_o}, 2);
    soft_rst_i = 1; tick(); clr();
    chk("R9 soft ignored", {30'b0, checkstop_o, fetch_vld_o}, 2);
    rfi_i = 1; bus_err_i = 1; tick(); clr();
    chk("R9 rfi ignored", {30'b0, checkstop_o, fetch_vld_o}, 2);
    load_msr(32'h0000_1040);
    chk("R9 msr load ignored", msr_o, 32'h0000_0000);
    next_ea_i = 32'h0000_A000;
    hard_rst_i = 1; tick(); clr();
    chk("R9 hard clears", {31'b0, checkstop_o}, 0);
    chk("R9 hard vector", fetch_addr_o, 32'h0000_0100);
    chk("R9 hard srr0", srr0_o, 32'h0000_A000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule